// File: doc/BRIEF.md
# Byte-Parallel CRC-32 Engine

This block keeps a 32-bit cyclic redundancy remainder and folds one whole data byte into it on every clock in which the byte is presented. There are no eight sequential shift-and-reduce steps per byte. Instead, the reduction for the byte that leaves the remainder comes from a lookup table of polynomial multiples. The design computes that table at elaboration time from its polynomial parameter. A parameter chooses between two table sizes. One is a 256-entry table indexed by a full byte, giving one lookup per byte. The other is a 16-entry table used twice per byte, one nibble at a time.

A second parameter sets the bit order. In the least-significant-first form the byte enters the low end of the remainder and the polynomial is bit-reversed. In the most-significant-first form the byte enters the top end. The remainder starts from all ones, and the output is always the remainder inverted.

A message whose length is not a whole number of bytes ends with a tail request. The request carries the last byte and a count of the valid bits in it, from 1 to 7. The block then reduces those bits one per clock and pulses a done flag after the last one. Framing around the message is left to the user.

Top module: `crc32_byte_engine`

## Requirements
- R1: While reset is asserted the remainder is all ones, so `crc_o` reads 0, and `busy_o` and `done_o` are 0.
- R2: `init_i` reloads the remainder with all ones on the next edge, giving `crc_o` = 0. It takes priority over `valid_i` in the same cycle and cancels a tail in progress, so `busy_o` goes to 0.
- R3: In least-significant-first mode (`LSB_FIRST`=1), a byte accepted with `valid_i`=1 and `tail_i`=0 updates `crc_o` on the next edge. The result equals a bit-serial reduction of data bit 0 first with the reflected polynomial 0xEDB88320. The ASCII bytes "123456789" after init give 0xCBF43926.
- R4: In most-significant-first mode (`LSB_FIRST`=0) the byte enters remainder bits 31:24. Data bit 7 goes first and the polynomial is 0x04C11DB7. "123456789" after init gives 0xFC891918.
- R5: The 16-entry variant (`INDEX_W`=4) gives, for every byte value and stream, the same `crc_o` as the 256-entry variant (`INDEX_W`=8) in the same bit order.
- R6: `crc_o` is the bitwise inverse of the internal remainder at all times.
- R7: A request with `valid_i`=1, `tail_i`=1 and `tail_bits_i`=n (1 to 7) reduces n bits of `data_i` one per edge. In least-significant-first mode these are bits 0..n-1; in most-significant-first mode they are bits 7 down to 8-n. `busy_o` is 1 for the n-1 cycles between. `done_o` is 1 for exactly the one cycle after the n-th edge.
- R8: While `busy_o` is 1, any byte or tail request on `valid_i` is ignored.
- R9: A tail request with `tail_bits_i`=0 leaves the remainder unchanged and raises neither `busy_o` nor `done_o`.
- R10: With `valid_i`=0, `init_i`=0 and `busy_o`=0, `crc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Reload remainder with all ones |
| valid_i | input | 1 | Byte or tail request present |
| data_i | input | 8 | Data byte |
| tail_i | input | 1 | Request is a fractional final byte |
| tail_bits_i | input | 3 | Number of valid bits in a tail byte |
| crc_o | output | 32 | Inverted remainder |
| busy_o | output | 1 | Tail bits still being reduced |
| done_o | output | 1 | One-cycle pulse after the last tail bit |

## Verification
The bench feeds every byte value after init, and one long unbroken stream, into all four combinations of bit order and table size. Each result is compared with a bit-serial model. A table generated with a wrong shift direction or polynomial orientation, or nibble steps done in the wrong order, shows up there as mismatched values.

Tail requests of every length 1 to 7 are checked for value and for the cycle in which `done_o` appears. This catches a design that takes bits from the wrong end of the byte or has an off-by-one in the step counter.

Further stimulus covers bytes presented during a tail, init while a tail is running, init together with valid, and zero-length tails. A design that let these disturb the remainder, or that failed to cancel the tail, would show a nonzero or shifted CRC afterwards.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

   localparam int MAX_W = 64;

   // reverse the low w bits of v
   function automatic logic [MAX_W-1:0] bit_rev(input logic [MAX_W-1:0] v, input int w);
      logic [MAX_W-1:0] r;
      r = '0;
      for (int i = 0; i < MAX_W; i++) begin
         if (i < w) r[i] = v[w-1-i];
      end
      return r;
   endfunction

endpackage

// File: rtl/crc_lut_gen.sv
module crc_lut_gen #(
   parameter int                W         = 32,
   parameter logic [W-1:0]      POLY_EFF  = '0,
   parameter bit                LSB_FIRST = 1'b1,
   parameter int                IDX_W     = 8,
   localparam int               NENT      = 1 << IDX_W
) (
   output logic [NENT*W-1:0]    lut_o
);

   // remainder of an IDX_W-bit message reduced from a zero start
   function automatic logic [W-1:0] entry(input int idx);
      logic [W-1:0] r;
      if (LSB_FIRST) begin
         r = W'(idx);
         for (int k = 0; k < IDX_W; k++)
            r = r[0] ? ((r >> 1) ^ POLY_EFF) : (r >> 1);
      end else begin
         r = W'(idx) << (W - IDX_W);
         for (int k = 0; k < IDX_W; k++)
            r = r[W-1] ? ((r << 1) ^ POLY_EFF) : (r << 1);
      end
      return r;
   endfunction

   for (genvar i = 0; i < NENT; i++) begin : g_ent
      assign lut_o[i*W +: W] = entry(i);
   end

endmodule

// File: rtl/crc_byte_stage.sv
module crc_byte_stage #(
   parameter int   W         = 32,
   parameter bit   LSB_FIRST = 1'b1,
   parameter int   IDX_W     = 8,
   localparam int  NENT      = 1 << IDX_W
) (
   input  logic [W-1:0]       crc_i,
   input  logic [7:0]         data_i,
   input  logic [NENT*W-1:0]  lut_i,
   output logic [W-1:0]       crc_o
);

   if (IDX_W == 8) begin : g_full
      logic [7:0] idx;
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            idx   = crc_i[7:0] ^ data_i;
            crc_o = (crc_i >> 8) ^ lut_i[idx*W +: W];
         end
      end else begin : g_msb
         always_comb begin
            idx   = crc_i[W-1 -: 8] ^ data_i;
            crc_o = (crc_i << 8) ^ lut_i[idx*W +: W];
         end
      end
   end else begin : g_nib
      logic [3:0]   ia, ib;
      logic [W-1:0] mid;
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            ia    = crc_i[3:0] ^ data_i[3:0];
            mid   = (crc_i >> 4) ^ lut_i[ia*W +: W];
            ib    = mid[3:0] ^ data_i[7:4];
            crc_o = (mid >> 4) ^ lut_i[ib*W +: W];
         end
      end else begin : g_msb
         always_comb begin
            ia    = crc_i[W-1 -: 4] ^ data_i[7:4];
            mid   = (crc_i << 4) ^ lut_i[ia*W +: W];
            ib    = mid[W-1 -: 4] ^ data_i[3:0];
            crc_o = (mid << 4) ^ lut_i[ib*W +: W];
         end
      end
   end

endmodule

// File: rtl/crc_bit_stage.sv
module crc_bit_stage #(
   parameter int            W         = 32,
   parameter logic [W-1:0]  POLY_EFF  = '0,
   parameter bit            LSB_FIRST = 1'b1
) (
   input  logic [W-1:0]  crc_i,
   input  logic          bit_i,
   output logic [W-1:0]  crc_o
);

   logic fb;

   if (LSB_FIRST) begin : g_lsb
      always_comb begin
         fb    = crc_i[0] ^ bit_i;
         crc_o = (crc_i >> 1) ^ (fb ? POLY_EFF : '0);
      end
   end else begin : g_msb
      always_comb begin
         fb    = crc_i[W-1] ^ bit_i;
         crc_o = (crc_i << 1) ^ (fb ? POLY_EFF : '0);
      end
   end

endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine #(
   parameter int                 CRC_W     = 32,
   parameter logic [CRC_W-1:0]   POLY      = 32'h04C1_1DB7,
   parameter bit                 LSB_FIRST = 1'b1,
   parameter int                 INDEX_W   = 8,
   parameter logic [CRC_W-1:0]   INIT      = '1,
   parameter logic [CRC_W-1:0]   XOR_OUT   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              valid_i,
   input  logic [7:0]        data_i,
   input  logic              tail_i,
   input  logic [2:0]        tail_bits_i,
   output logic [CRC_W-1:0]  crc_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int NENT   = 1 << INDEX_W;
   localparam int CNT_W  = 3;
   localparam logic [CRC_W-1:0] POLY_EFF = LSB_FIRST ?
      CRC_W'(crc_eng_pkg::bit_rev(64'(POLY), CRC_W)) : POLY;

   if (INDEX_W != 8 && INDEX_W != 4) begin : g_bad_idx
      $error("INDEX_W must be 4 or 8");
   end
   if (CRC_W < 8 || CRC_W > crc_eng_pkg::MAX_W) begin : g_bad_w
      $error("CRC_W out of range");
   end

   logic [CRC_W-1:0]   rem_q;
   logic [7:0]         tdata_q;
   logic [CNT_W-1:0]   pos_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               done_q;
   logic               busy;

   logic [NENT*CRC_W-1:0] lut;
   logic [CRC_W-1:0]      byte_next;
   logic [CRC_W-1:0]      bit_next;
   logic [7:0]            bsrc_data;
   logic [CNT_W-1:0]      bsrc_pos;
   logic                  bsrc;

   crc_lut_gen #(
      .W(CRC_W), .POLY_EFF(POLY_EFF), .LSB_FIRST(LSB_FIRST), .IDX_W(INDEX_W)
   ) u_lut (
      .lut_o(lut)
   );

   crc_byte_stage #(
      .W(CRC_W), .LSB_FIRST(LSB_FIRST), .IDX_W(INDEX_W)
   ) u_byte (
      .crc_i(rem_q), .data_i(data_i), .lut_i(lut), .crc_o(byte_next)
   );

   assign busy = (cnt_q != '0);

   // bit source: incoming byte on acceptance, stored byte while stepping
   always_comb begin
      bsrc_data = busy ? tdata_q : data_i;
      bsrc_pos  = busy ? pos_q   : '0;
      bsrc      = LSB_FIRST ? bsrc_data[bsrc_pos] : bsrc_data[3'd7 - bsrc_pos];
   end

   crc_bit_stage #(
      .W(CRC_W), .POLY_EFF(POLY_EFF), .LSB_FIRST(LSB_FIRST)
   ) u_bit (
      .crc_i(rem_q), .bit_i(bsrc), .crc_o(bit_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= INIT;
         tdata_q <= '0;
         pos_q   <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else if (init_i) begin
         rem_q   <= INIT;
         cnt_q   <= '0;
         pos_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy) begin
            rem_q <= bit_next;
            cnt_q <= cnt_q - 1'b1;
            pos_q <= pos_q + 1'b1;
            if (cnt_q == 3'd1) done_q <= 1'b1;
         end else if (valid_i) begin
            if (!tail_i) begin
               rem_q <= byte_next;
            end else if (tail_bits_i != '0) begin
               rem_q   <= bit_next;
               tdata_q <= data_i;
               pos_q   <= 3'd1;
               cnt_q   <= tail_bits_i - 1'b1;
               if (tail_bits_i == 3'd1) done_q <= 1'b1;
            end
         end
      end
   end

   assign crc_o  = rem_q ^ XOR_OUT;
   assign busy_o = busy;
   assign done_o = done_q;

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
   parameter int CRC_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init_i,
   input logic              valid_i,
   input logic              tail_i,
   input logic [2:0]        tail_bits_i,
   input logic [CRC_W-1:0]  crc_o,
   input logic              busy_o,
   input logic              done_o
);

   // R1: reset holds the all-ones remainder and an idle controller
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (crc_o == '0 && !busy_o && !done_o));

   // R2: init reloads and cancels any tail
   a_r2_init_reload: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (crc_o == '0 && !busy_o && !done_o));

   // R7: a running tail ends in busy or in the done pulse
   a_r7_tail_progress: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !init_i) |=> (busy_o || done_o));

   // R7: done never overlaps busy
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R9: zero-length tail has no effect
   a_r9_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && tail_i && tail_bits_i == 3'd0 && !busy_o && !init_i)
      |=> ($stable(crc_o) && !busy_o && !done_o));

   // R10: idle cycles keep the value
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && !init_i && !busy_o) |=> $stable(crc_o));

endmodule

bind crc32_byte_engine crc_engine_chk #(.CRC_W(CRC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .init_i(init_i), .valid_i(valid_i),
   .tail_i(tail_i), .tail_bits_i(tail_bits_i), .crc_o(crc_o),
   .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_crc32_byte_engine.sv
module tb_crc32_byte_engine;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_i = 1'b0;
   logic        valid_i = 1'b0;
   logic [7:0]  data_i = '0;
   logic        tail_i = 1'b0;
   logic [2:0]  tail_bits_i = '0;

   // index 0: lsb/8, 1: lsb/4, 2: msb/8, 3: msb/4
   logic [31:0] crc [4];
   logic [3:0]  busy, done;
   logic [31:0] rl, rm;   // model remainders

   int tests = 0, fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc32_byte_engine #(.LSB_FIRST(1'b1), .INDEX_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .valid_i(valid_i), .data_i(data_i),
      .tail_i(tail_i), .tail_bits_i(tail_bits_i), .crc_o(crc[0]), .busy_o(busy[0]), .done_o(done[0]));
   crc32_byte_engine #(.LSB_FIRST(1'b1), .INDEX_W(4)) dut_l4 (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .valid_i(valid_i), .data_i(data_i),
      .tail_i(tail_i), .tail_bits_i(tail_bits_i), .crc_o(crc[1]), .busy_o(busy[1]), .done_o(done[1]));
   crc32_byte_engine #(.LSB_FIRST(1'b0), .INDEX_W(8)) dut_m8 (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .valid_i(valid_i), .data_i(data_i),
      .tail_i(tail_i), .tail_bits_i(tail_bits_i), .crc_o(crc[2]), .busy_o(busy[2]), .done_o(done[2]));
   crc32_byte_engine #(.LSB_FIRST(1'b0), .INDEX_W(4)) dut_m4 (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .valid_i(valid_i), .data_i(data_i),
      .tail_i(tail_i), .tail_bits_i(tail_bits_i), .crc_o(crc[3]), .busy_o(busy[3]), .done_o(done[3]));

   function automatic logic [31:0] m_lsb(input logic [31:0] r, input logic [7:0] d, input int n);
      for (int k = 0; k < n; k++) begin
         logic fb;
         fb = r[0] ^ d[k];
         r  = r >> 1;
         if (fb) r = r ^ 32'hEDB8_8320;
      end
      return r;
   endfunction

   function automatic logic [31:0] m_msb(input logic [31:0] r, input logic [7:0] d, input int n);
      for (int k = 0; k < n; k++) begin
         logic fb;
         fb = r[31] ^ d[7-k];
         r  = r << 1;
         if (fb) r = r ^ 32'h04C1_1DB7;
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk({req, " lsb8"}, crc[0], ~rl);
      chk({req, " lsb4 R5"}, crc[1], ~rl);
      chk({req, " msb8"}, crc[2], ~rm);
      chk({req, " msb4 R5"}, crc[3], ~rm);
   endtask

   task automatic do_init();
      init_i = 1'b1;
      @(negedge clk);
      init_i = 1'b0;
      rl = '1; rm = '1;
   endtask

   task automatic send(input logic [7:0] b);
      valid_i = 1'b1; tail_i = 1'b0; data_i = b;
      @(negedge clk);
      valid_i = 1'b0;
      rl = m_lsb(rl, b, 8); rm = m_msb(rm, b, 8);
   endtask

   task automatic send_tail(input logic [7:0] b, input int n);
      int cyc;
      valid_i = 1'b1; tail_i = 1'b1; tail_bits_i = 3'(n); data_i = b;
      @(negedge clk);
      valid_i = 1'b0; tail_i = 1'b0;
      chk("R7 busy after accept", 32'(busy[0]), 32'(n > 1));
      cyc = 1;
      while (!done[0] && cyc < 12) begin
         @(negedge clk);
         cyc++;
      end
      chk("R7 tail cycles", 32'(cyc), 32'(n));
      rl = m_lsb(rl, b, n); rm = m_msb(rm, b, n);
      chk_all("R7 tail value");
      @(negedge clk);
      chk("R7 done one cycle", 32'(done), 32'(0));
   endtask

   initial begin
      string s;
      rl = '1; rm = '1;
      repeat (3) @(negedge clk);
      chk("R1 reset crc", crc[0], 32'h0);
      chk("R1 reset flags", {28'h0, busy | done}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 standard check string
      do_init();
      s = "123456789";
      for (int i = 0; i < 9; i++) send(s[i]);
      chk("R3 check string", crc[0], 32'hCBF4_3926);
      chk("R4 check string", crc[2], 32'hFC89_1918);
      chk("R5 check string lsb4", crc[1], 32'hCBF4_3926);
      chk("R5 check string msb4", crc[3], 32'hFC89_1918);
      chk("R6 inverted output", crc[0], ~rl);

      // R3 R4 R5: every single-byte message
      for (int v = 0; v < 256; v++) begin
         do_init();
         send(8'(v));
         chk_all("R3 R4 single byte");
      end

      // long stream without init
      do_init();
      for (int v = 0; v < 256; v++) send(8'(v * 37 + 11));
      chk_all("R3 R4 stream");

      // R10 idle hold
      repeat (4) @(negedge clk);
      chk_all("R10 idle hold");

      // R7 tails of every length
      for (int n = 1; n <= 7; n++) begin
         do_init();
         send(8'h5A); send(8'(n * 29));
         send_tail(8'hA5 ^ 8'(n), n);
         send_tail(8'h3C, n);
      end

      // R8 bytes during a tail are ignored
      do_init();
      send(8'h12);
      valid_i = 1'b1; tail_i = 1'b1; tail_bits_i = 3'd7; data_i = 8'hC9;
      @(negedge clk);
      tail_i = 1'b0; data_i = 8'hFF;        // valid stays high while busy
      repeat (3) @(negedge clk);
      valid_i = 1'b0;
      repeat (4) @(negedge clk);
      rl = m_lsb(rl, 8'hC9, 7); rm = m_msb(rm, 8'hC9, 7);
      chk_all("R8 ignored while busy");

      // R9 zero-length tail
      valid_i = 1'b1; tail_i = 1'b1; tail_bits_i = 3'd0; data_i = 8'h77;
      @(negedge clk);
      valid_i = 1'b0; tail_i = 1'b0;
      chk_all("R9 zero tail");
      chk("R9 flags", {28'h0, busy | done}, 32'h0);

      // R2 init cancels a tail in progress
      valid_i = 1'b1; tail_i = 1'b1; tail_bits_i = 3'd6; data_i = 8'h81;
      @(negedge clk);
      valid_i = 1'b0; tail_i = 1'b0;
      @(negedge clk);
      do_init();
      chk_all("R2 init cancels tail");
      chk("R2 busy cleared", 32'(busy), 32'h0);
      repeat (6) @(negedge clk);
      chk("R2 no late done", 32'(done), 32'h0);
      chk_all("R2 value kept");

      // R2 init wins over valid
      send(8'h44);
      init_i = 1'b1; valid_i = 1'b1; data_i = 8'h99;
      @(negedge clk);
      init_i = 1'b0; valid_i = 1'b0;
      rl = '1; rm = '1;
      chk_all("R2 init over valid");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule